// File: doc/BRIEF.md
# Two-Line Secondary Interrupt Stage

This block collects up to 32 raw event inputs from one peripheral and presents them to two independent host masters. Each input is synchronized and passed through a per-source edge selector. The resulting events are latched into status registers. Each host line has its own status bank and its own mask bank, so each master can see and acknowledge events without disturbing the other. Each line drives a registered interrupt request output.

A byte-wide register port gives access to all state. A control register picks how status is acknowledged: either by reading it or by writing ones to it. The same register picks whether a second event that arrives while a bit is still set is held back and re-posted after the clear. It also picks whether events go to both banks or to one selected bank only. A test register lets software force status bits. Status and mask registers occupy ceil(N/8) bytes each, and the edge register occupies ceil(2N/8) bytes.

Top module: `sih_unit`

## Requirements
- R1: After reset, every status bit is 0, every mask bit is 1, the edge register and control register are 0, and both request outputs are low.
- R2: Source i has a rising-edge enable at edge-register bit 2i and a falling-edge enable at bit 2i+1. An enabled edge on the synchronized input sets status bit i. When exclusive mode is off, the event is recorded in both banks.
- R3: A source whose two edge-enable bits are both 0 never sets status, whatever its input does.
- R4: Request output L is a registered OR, over all sources, of (status AND NOT mask) for bank L. A mask bit of 1 blocks its source from that line only. Masking never clears status.
- R5: Writing 0xFF to every mask byte of a line drives that line's request low on the next cycle.
- R6: With the clear-on-read control bit (bit 3) set, a read of a status byte returns the set bits and clears exactly those bits. Writes to status bytes then have no effect.
- R7: With the clear-on-read bit clear, writing 1s to a status byte clears those bits. Reads leave status unchanged.
- R8: Clearing a bit in one line's bank leaves the other line's bank and request unchanged.
- R9: With the pending-disable control bit (bit 2) at 0, an event on a bit that is already set is held. That bit reads as set again after the first clear. With pending-disable at 1, the event is dropped.
- R10: Writing 1s to a byte of the force register sets the matching status bits.
- R11: With the exclusive control bit (bit 0) set, events and forced bits go only to the bank chosen by control bit 1 (0 = line 0, 1 = line 1).
- R12: When a clear and a new event hit the same set bit in the same cycle, the bit stays set.
- R13: Register map, byte k holding sources 8k to 8k+7. Line 0 status is at 0x00+k and line 0 mask at 0x04+k. Line 1 status is at 0x08+k and line 1 mask at 0x0C+k. The force register is at 0x10+k. Edge bytes start at 0x14, and the control register is at 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access (drives clear-on-read) |
| bus_rdata | output | 8 | Read data for the addressed byte, combinational |
| src_in | input | N_SRC | Raw asynchronous event inputs |
| irq_o | output | 2 | Request outputs, bit 0 for line 0 and bit 1 for line 1 |

## Verification
A walking single rising edge across all 24 sources shows that each source lands in the right byte and bit of both banks and raises both lines. Any crossed or shifted bit fails the sweep. A burst on all sources together under a falling-only setting separates the two edge enables. The same burst with both enables clear proves that such sources stay silent. Repeated edges on one source, with the pending buffer on and then off, tell a held second event apart from a dropped one. A clear timed to meet a fresh event in the same cycle shows which of the two takes priority. Mixing clear modes, masks and exclusive routing shows that the two banks stay apart.

// File: rtl/sih_pkg.sv
package sih_pkg;
   localparam int ISR_STRIDE = 8;
   localparam int ISR0_ADDR  = 'h00;
   localparam int IMR0_ADDR  = 'h04;
   localparam int FORCE_ADDR = 'h10;
   localparam int EDGE_ADDR  = 'h14;
   localparam int CTRL_ADDR  = 'h1C;

   typedef struct packed {
      logic cor;
      logic pdis;
      logic xsel;
      logic excl;
   } ctrl_t;

   function automatic int isr_addr(input int line);
      return ISR0_ADDR + ISR_STRIDE * line;
   endfunction

   function automatic int imr_addr(input int line);
      return IMR0_ADDR + ISR_STRIDE * line;
   endfunction
endpackage

// File: rtl/sih_edge.sv
module sih_edge #(
   parameter int N_SRC       = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_in,
   input  logic [N_SRC-1:0] rise_en,
   input  logic [N_SRC-1:0] fall_en,
   output logic [N_SRC-1:0] event_o
);
   logic [N_SRC-1:0] sync_q [SYNC_STAGES];
   logic [N_SRC-1:0] prev_q;
   logic [N_SRC-1:0] cur;

   initial begin : p_param_chk
      assert (SYNC_STAGES >= 2) else $error("sih_edge: SYNC_STAGES must be >= 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
         prev_q <= '0;
      end else begin
         sync_q[0] <= src_in;
         for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign cur     = sync_q[SYNC_STAGES-1];
   assign event_o = (cur & ~prev_q & rise_en) | (~cur & prev_q & fall_en);
endmodule

// File: rtl/sih_bank.sv
module sih_bank #(
   parameter int N_SRC = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] hit,
   input  logic [N_SRC-1:0] clr,
   input  logic             pdis,
   input  logic [N_SRC-1:0] mask,
   output logic [N_SRC-1:0] status,
   output logic             irq
);
   logic [N_SRC-1:0] st_q, bf_q;
   logic             irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= '0;
         bf_q  <= '0;
         irq_q <= 1'b0;
      end else begin
         st_q  <= (st_q & ~clr) | hit | (st_q & clr & bf_q);
         bf_q  <= pdis ? '0
                       : ((bf_q & ~(st_q & clr)) | (st_q & hit & (~clr | bf_q)));
         irq_q <= |(st_q & ~mask);
      end
   end

   assign status = st_q;
   assign irq    = irq_q;

   // R7
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(st_q) & ~$past(clr) & ~st_q) == '0));

   // R9
   buf_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bf_q & ~st_q) == '0);

   // R9
   pdis_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pdis |=> (bf_q == '0));

   // R5
   full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask) |=> !irq_q);
endmodule

// File: rtl/sih_unit.sv
module sih_unit
   import sih_pkg::*;
#(
   parameter int N_SRC       = 24,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_rd,
   output logic [7:0]        bus_rdata,
   input  logic [N_SRC-1:0]  src_in,
   output logic [1:0]        irq_o
);
   localparam int NB = (N_SRC + 7) / 8;
   localparam int NP = NB * 8;
   localparam int NE = (2 * N_SRC + 7) / 8;
   localparam int EP = NE * 8;
   localparam int NLINE = 2;

   initial begin : p_param_chk
      assert (N_SRC >= 1 && N_SRC <= 32) else $error("sih_unit: N_SRC out of range");
      assert (ADDR_W >= 5) else $error("sih_unit: ADDR_W too small for map");
   end

   ctrl_t            ctrl_q;
   logic [NP-1:0]    mask_p  [NLINE];
   logic [NP-1:0]    st_p    [NLINE];
   logic [NP-1:0]    clr_p   [NLINE];
   logic [N_SRC-1:0] st      [NLINE];
   logic [N_SRC-1:0] hit     [NLINE];
   logic [NP-1:0]    force_p;
   logic [EP-1:0]    edge_q;
   logic [N_SRC-1:0] rise_en, fall_en, ev, raw_hit;

   function automatic logic at(input logic [ADDR_W-1:0] a, input int target);
      return a == ADDR_W'(target);
   endfunction

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         edge_q <= '0;
         for (int l = 0; l < NLINE; l++) mask_p[l] <= '1;
      end else if (bus_wr) begin
         if (at(bus_addr, CTRL_ADDR)) ctrl_q <= ctrl_t'(bus_wdata[3:0]);
         for (int k = 0; k < NE; k++)
            if (at(bus_addr, EDGE_ADDR + k)) edge_q[8*k +: 8] <= bus_wdata;
         for (int l = 0; l < NLINE; l++)
            for (int k = 0; k < NB; k++)
               if (at(bus_addr, imr_addr(l) + k)) mask_p[l][8*k +: 8] <= bus_wdata;
      end
   end

   always_comb begin
      for (int i = 0; i < N_SRC; i++) begin
         rise_en[i] = edge_q[2*i];
         fall_en[i] = edge_q[2*i+1];
      end
   end

   sih_edge #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_in  (src_in),
      .rise_en (rise_en),
      .fall_en (fall_en),
      .event_o (ev)
   );

   // force strobes and per-line clear strobes
   always_comb begin
      force_p = '0;
      for (int l = 0; l < NLINE; l++) clr_p[l] = '0;
      for (int k = 0; k < NB; k++) begin
         if (bus_wr && at(bus_addr, FORCE_ADDR + k)) force_p[8*k +: 8] = bus_wdata;
         for (int l = 0; l < NLINE; l++) begin
            if (at(bus_addr, isr_addr(l) + k)) begin
               if (ctrl_q.cor) begin
                  if (bus_rd) clr_p[l][8*k +: 8] = st_p[l][8*k +: 8];
               end else if (bus_wr) begin
                  clr_p[l][8*k +: 8] = bus_wdata;
               end
            end
         end
      end
   end

   assign raw_hit = ev | force_p[N_SRC-1:0];

   generate
      for (genvar l = 0; l < NLINE; l++) begin : g_line
         logic route;
         assign route  = !ctrl_q.excl || (ctrl_q.xsel == l[0]);
         assign hit[l] = route ? raw_hit : '0;

         sih_bank #(.N_SRC(N_SRC)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit[l]),
            .clr    (clr_p[l][N_SRC-1:0]),
            .pdis   (ctrl_q.pdis),
            .mask   (mask_p[l][N_SRC-1:0]),
            .status (st[l]),
            .irq    (irq_o[l])
         );
         assign st_p[l] = NP'(st[l]);

         // R11
         excl_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q.excl && (ctrl_q.xsel != l[0])) |-> (hit[l] == '0));
      end
   endgenerate

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (at(bus_addr, CTRL_ADDR)) bus_rdata = {4'b0, ctrl_q};
      for (int k = 0; k < NE; k++)
         if (at(bus_addr, EDGE_ADDR + k)) bus_rdata = edge_q[8*k +: 8];
      for (int l = 0; l < NLINE; l++)
         for (int k = 0; k < NB; k++) begin
            if (at(bus_addr, isr_addr(l) + k)) bus_rdata = st_p[l][8*k +: 8];
            if (at(bus_addr, imr_addr(l) + k)) bus_rdata = mask_p[l][8*k +: 8];
         end
   end
endmodule

// File: tb/sih_unit_bench.sv
module sih_unit_bench;
   localparam int N = 24;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr = 1'b0, rd = 1'b0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic [N-1:0]  src = '0;
   logic [1:0]    irq;
   int            checks = 0, errors = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   sih_unit #(.N_SRC(N), .ADDR_W(AW), .SYNC_STAGES(2)) u_sih_unit (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
      .bus_rd(rd), .bus_rdata(rdata), .src_in(src), .irq_o(irq)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wreg(input int a, input logic [7:0] d);
      @(negedge clk);
      addr = AW'(a); wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rreg(input int a, output logic [7:0] d);
      @(negedge clk);
      addr = AW'(a); rd = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic expect_reg(input int a, input logic [7:0] e, input string tag);
      logic [7:0] d;
      rreg(a, d);
      check(d == e, tag, d, e);
   endtask

   task automatic waitc(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic clear_all();
      for (int k = 0; k < 3; k++) begin
         wreg(8'h00 + k, 8'hFF);
         wreg(8'h08 + k, 8'hFF);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] d;
      waitc(3);
      @(negedge clk) rst_n = 1'b1;
      waitc(2);

      // R1 reset state
      check(irq == 2'b00, "R1 irq", irq, 0);
      for (int k = 0; k < 3; k++) begin
         expect_reg(8'h04 + k, 8'hFF, "R1 mask0");
         expect_reg(8'h0C + k, 8'hFF, "R1 mask1");
         expect_reg(8'h00 + k, 8'h00, "R1 status0");
      end
      expect_reg(8'h14, 8'h00, "R1 edge");
      expect_reg(8'h1C, 8'h00, "R1 ctrl");

      // setup: rising-only on all sources, unmask both lines (R13 map)
      for (int k = 0; k < 6; k++) wreg(8'h14 + k, 8'h55);
      for (int k = 0; k < 3; k++) begin
         wreg(8'h04 + k, 8'h00);
         wreg(8'h0C + k, 8'h00);
      end

      // R2 R4 walking rising edge over every source
      for (int i = 0; i < N; i++) begin
         @(negedge clk) src[i] = 1'b1;
         waitc(6);
         check(irq == 2'b11, "R4 irq both", irq, 3);
         expect_reg(i / 8, 8'(1 << (i % 8)), "R2 line0 bit");
         expect_reg(8 + i / 8, 8'(1 << (i % 8)), "R2 line1 bit");
         wreg(i / 8, 8'(1 << (i % 8)));
         wreg(8 + i / 8, 8'(1 << (i % 8)));
         waitc(2);
         check(irq == 2'b00, "R7 irq after write clear", irq, 0);
         @(negedge clk) src[i] = 1'b0;
         waitc(6);
         check(irq == 2'b00, "R2 falling ignored", irq, 0);
      end

      // R2 falling-only, all sources together
      for (int k = 0; k < 6; k++) wreg(8'h14 + k, 8'hAA);
      @(negedge clk) src = '1;
      waitc(6);
      check(irq == 2'b00, "R2 rising ignored", irq, 0);
      @(negedge clk) src = '0;
      waitc(6);
      for (int k = 0; k < 3; k++) expect_reg(k, 8'hFF, "R2 falling all");
      clear_all();

      // R3 both enables clear
      for (int k = 0; k < 6; k++) wreg(8'h14 + k, 8'h00);
      @(negedge clk) src = '1;
      waitc(6);
      @(negedge clk) src = '0;
      waitc(6);
      for (int k = 0; k < 3; k++) expect_reg(k, 8'h00, "R3 no event");
      check(irq == 2'b00, "R3 irq", irq, 0);

      // R4 R5 masking
      for (int k = 0; k < 6; k++) wreg(8'h14 + k, 8'h55);
      @(negedge clk) src[3] = 1'b1;
      waitc(6);
      wreg(8'h04, 8'h08);
      waitc(2);
      check(irq == 2'b10, "R4 mask line0 only", irq, 2);
      for (int k = 0; k < 3; k++) wreg(8'h0C + k, 8'hFF);
      waitc(2);
      check(irq == 2'b00, "R5 full mask", irq, 0);
      expect_reg(8'h08, 8'h08, "R4 mask keeps status");
      wreg(8'h04, 8'h00);
      for (int k = 0; k < 3; k++) wreg(8'h0C + k, 8'h00);
      waitc(2);
      check(irq == 2'b11, "R4 unmask", irq, 3);

      // R8 independence
      wreg(8'h00, 8'h08);
      waitc(2);
      check(irq == 2'b10, "R8 line1 request kept", irq, 2);
      expect_reg(8'h08, 8'h08, "R8 line1 status kept");
      wreg(8'h08, 8'h08);

      // R6 clear-on-read
      wreg(8'h1C, 8'h08);
      @(negedge clk) src[3] = 1'b0;
      waitc(6);
      @(negedge clk) src[3] = 1'b1;
      waitc(6);
      wreg(8'h00, 8'hFF);
      expect_reg(8'h00, 8'h08, "R6 write ignored, read returns");
      expect_reg(8'h00, 8'h00, "R6 read cleared");
      expect_reg(8'h08, 8'h08, "R6 R8 other line kept");
      expect_reg(8'h08, 8'h00, "R6 line1 read cleared");

      // R7 clear-on-write, reads do not clear
      wreg(8'h1C, 8'h00);
      @(negedge clk) src[3] = 1'b0;
      waitc(6);
      @(negedge clk) src[3] = 1'b1;
      waitc(6);
      expect_reg(8'h00, 8'h08, "R7 read 1");
      expect_reg(8'h00, 8'h08, "R7 read 2 unchanged");
      wreg(8'h00, 8'h08);
      expect_reg(8'h00, 8'h00, "R7 write cleared");
      wreg(8'h08, 8'h08);

      // R10 force register
      wreg(8'h12, 8'h81);
      expect_reg(8'h02, 8'h81, "R10 force line0");
      expect_reg(8'h0A, 8'h81, "R10 force line1");
      clear_all();

      // R11 exclusive routing
      wreg(8'h1C, 8'h03);
      wreg(8'h11, 8'h04);
      expect_reg(8'h01, 8'h00, "R11 line0 excluded");
      expect_reg(8'h09, 8'h04, "R11 line1 selected");
      wreg(8'h1C, 8'h01);
      @(negedge clk) src[3] = 1'b0;
      waitc(6);
      @(negedge clk) src[3] = 1'b1;
      waitc(6);
      expect_reg(8'h00, 8'h08, "R11 event to line0");
      expect_reg(8'h08, 8'h00, "R11 line1 excluded");
      wreg(8'h1C, 8'h00);
      clear_all();

      // R9 pending buffer enabled
      for (int p = 0; p < 2; p++) begin
         wreg(8'h1C, p ? 8'h04 : 8'h00);
         @(negedge clk) src[5] = 1'b1;
         waitc(6);
         @(negedge clk) src[5] = 1'b0;
         waitc(6);
         @(negedge clk) src[5] = 1'b1;
         waitc(6);
         expect_reg(8'h00, 8'h20, "R9 first event");
         wreg(8'h00, 8'h20);
         expect_reg(8'h00, p ? 8'h00 : 8'h20, p ? "R9 dropped when disabled" : "R9 buffered repost");
         wreg(8'h00, 8'h20);
         expect_reg(8'h00, 8'h00, "R9 second clear");
         @(negedge clk) src[5] = 1'b0;
         waitc(6);
         clear_all();
      end

      // R12 clear and new event in the same cycle
      wreg(8'h1C, 8'h04);
      @(negedge clk) src[6] = 1'b1;
      waitc(6);
      @(negedge clk) src[6] = 1'b0;
      waitc(6);
      expect_reg(8'h00, 8'h40, "R12 preset");
      @(negedge clk) src[6] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      wreg(8'h00, 8'h40);
      waitc(2);
      expect_reg(8'h00, 8'h40, "R12 event wins");
      wreg(8'h00, 8'h40);
      expect_reg(8'h00, 8'h00, "R12 later clear");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule